// File: doc/BRIEF.md
# Packet Program-Counter Sequencer with Zero-Overhead Repeat Loop

This block holds the program counter of a processor that issues fixed 8-byte instruction packets, and it works out the address of the following packet once per retired packet. Three things can redirect the flow besides a taken branch. The first is a hardware repeat loop, described by a start address, an end address, an iteration count and a repeat-enable bit in the status word. The second is an instruction-address breakpoint that enters a debug trap. The third is a maskable external interrupt. Both traps enter at fixed vectors and save the return state into dedicated registers.

Each cycle the issue logic either retires a packet or does not. A retired packet brings its branch outcome and any write it makes to the count or to the status word. The sequencer applies the loop rules around that packet, then the breakpoint check, and then the interrupt check. An interrupt that arrives while interrupts are masked is kept as one pending request and is retried every cycle. The stack-bank select follows the supervisor-mode bit whenever the status word is rewritten by a packet or by interrupt entry.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, every register clears: `pc`, `loop_count`, `psw`, both saved PCs, both saved status words, `stk_bank` and `irq_pending` all become zero.
- R2: A retired packet (`step`=1) with no branch, not at the loop end, sets `pc` to `pc`+8.
- R3: A taken branch (`br_valid`=1 with `step`) sets `pc` to `br_target`, ahead of the loop-back and the +8 increment.
- R4: At `pc`==`loop_end`, a retired packet decrements the count when the count held before the packet is nonzero or RP (`psw` bit 0) is set. A count of zero then wraps to all ones. A count write by the same packet (`cnt_we`) replaces the decremented value, but it does not change whether the loop branches back.
- R5: Without a branch, `pc` becomes `loop_start` when RP is set after the packet, the count held before the packet is nonzero, and `pc`==`loop_end`.
- R6: RP is cleared when it is set after the packet, `pc`==`loop_end`, and the count after the packet is zero.
- R7: A retired packet at `pc`==`bkpt_addr` with DB (`psw` bit 3) set takes the debug trap. `dbg_pc` receives the next PC computed by the loop rules. `dbg_psw` receives the status word with EA (bit 4) set. `psw` keeps only SM (bit 5) and gains DS (bit 2). `pc` becomes 0xFFFFF128.
- R8: The breakpoint is evaluated after the loop rules, so the count decrement and the RP clear of that packet still take effect when the debug trap is taken.
- R9: A request (`irq` or pending) with IE (`psw` bit 1) set, as seen after this cycle's packet, enters the interrupt. `bak_psw` receives that status word and `bak_pc` receives that next PC. `psw` clears, `pc` becomes 0xFFFFF138 and `stk_bank` becomes 0.
- R10: A request while IE is clear sets `irq_pending`. The pending request is retried every cycle until IE is set, and then it is delivered exactly once. Requests that arrive while one is pending are dropped.
- R11: A packet status write (`psw_we` with `step`) loads `psw` from `psw_wdata`, and `stk_bank` takes the new SM bit.
- R12: With `step`=0 and no interrupt, `pc`, `loop_count`, `psw` and the saved registers keep their values, and branch, count and status inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | A packet retires this cycle |
| br_valid | input | 1 | The retiring packet took a branch |
| br_target | input | 32 | Branch destination |
| loop_start | input | 32 | First packet address of the repeat loop |
| loop_end | input | 32 | Last packet address of the repeat loop |
| cnt_we | input | 1 | The retiring packet writes the loop count |
| cnt_wdata | input | 16 | Count value written by the packet |
| psw_we | input | 1 | The retiring packet writes the status word |
| psw_wdata | input | 6 | Status value written by the packet |
| bkpt_addr | input | 32 | Instruction breakpoint address |
| irq | input | 1 | External interrupt request |
| pc | output | 32 | Current program counter |
| loop_count | output | 16 | Current repeat count |
| psw | output | 6 | Status word {SM,EA,DB,DS,IE,RP}, bit 5 down to bit 0 |
| dbg_pc | output | 32 | PC saved by the debug trap |
| dbg_psw | output | 6 | Status saved by the debug trap |
| bak_pc | output | 32 | PC saved by interrupt entry |
| bak_psw | output | 6 | Status saved by interrupt entry |
| stk_bank | output | 1 | Selected stack bank |
| irq_pending | output | 1 | A masked interrupt is being held |

## Verification
The sequencer is driven with straight-line packets, with a two-pass repeat loop that exits by itself, and with a loop whose count is overwritten at the end address. That last case separates the count held before the packet from the count written by the packet. A count of zero with RP set shows the wrap of the decrement. A breakpoint on the loop end shows that the loop state moves on before the debug trap is taken. Masked interrupt bursts that are unmasked later show that one request is held and the rest are dropped. A long mixed phase combines branches, writes, breakpoints and interrupts, and a behavioural model is compared against every output on every cycle.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
    localparam int PSW_W = 6;

    typedef struct packed {
        logic sm;
        logic ea;
        logic db;
        logic ds;
        logic ie;
        logic rp;
    } psw_t;

    function automatic psw_t debug_entry_psw(psw_t p);
        psw_t r;
        r    = '0;
        r.sm = p.sm;
        r.ds = 1'b1;
        return r;
    endfunction

    function automatic psw_t mark_exception(psw_t p);
        psw_t r;
        r    = p;
        r.ea = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/loop_ctrl.sv
`timescale 1ns/1ps
module loop_ctrl
    import seq_pkg::*;
#(
    parameter int AW        = 32,
    parameter int CW        = 16,
    parameter int PKT_BYTES = 8
) (
    input  logic [AW-1:0] pc,
    input  logic [CW-1:0] cnt,
    input  logic          rp_pre,
    input  psw_t          psw_exec,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          br_valid,
    input  logic [AW-1:0] br_target,
    input  logic [AW-1:0] loop_start,
    input  logic [AW-1:0] loop_end,
    output logic [CW-1:0] cnt_after,
    output psw_t          psw_after,
    output logic [AW-1:0] npc,
    output logic          loop_back
);
    localparam logic [AW-1:0] STRIDE = AW'(PKT_BYTES);

    logic          at_end;
    logic          cnt_nz;
    logic          do_dec;
    logic [CW-1:0] cnt_dec;

    always_comb begin
        at_end  = (pc == loop_end);
        cnt_nz  = (cnt != '0);
        do_dec  = at_end && (cnt_nz || rp_pre);
        cnt_dec = do_dec ? cnt - 1'b1 : cnt;
        cnt_after = cnt_we ? cnt_wdata : cnt_dec;

        psw_after = psw_exec;
        if (psw_exec.rp && at_end && (cnt_after == '0))
            psw_after.rp = 1'b0;

        loop_back = psw_exec.rp && cnt_nz && at_end;

        if (br_valid)
            npc = br_target;
        else if (loop_back)
            npc = loop_start;
        else
            npc = pc + STRIDE;
    end
endmodule

// File: rtl/trap_ctrl.sv
`timescale 1ns/1ps
module trap_ctrl
    import seq_pkg::*;
#(
    parameter int              AW      = 32,
    parameter logic [AW-1:0]   DBG_VEC = 'hFFFF_F128
) (
    input  logic [AW-1:0] cia,
    input  logic [AW-1:0] bkpt_addr,
    input  psw_t          psw_in,
    input  logic [AW-1:0] npc,
    output logic          take,
    output logic [AW-1:0] pc_out,
    output psw_t          psw_out,
    output psw_t          saved_psw
);
    always_comb begin
        take      = (cia == bkpt_addr) && psw_in.db;
        saved_psw = mark_exception(psw_in);
        pc_out    = take ? DBG_VEC : npc;
        psw_out   = take ? debug_entry_psw(saved_psw) : psw_in;
    end
endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl
    import seq_pkg::*;
#(
    parameter int            AW      = 32,
    parameter logic [AW-1:0] IRQ_VEC = 'hFFFF_F138
) (
    input  logic          irq,
    input  logic          pend,
    input  psw_t          psw_in,
    input  logic [AW-1:0] pc_in,
    output logic          take,
    output logic          pend_next,
    output logic [AW-1:0] pc_out,
    output psw_t          psw_out
);
    logic req;

    always_comb begin
        req       = irq || pend;
        take      = req && psw_in.ie;
        pend_next = req && !psw_in.ie;
        pc_out    = take ? IRQ_VEC : pc_in;
        psw_out   = take ? psw_t'('0) : psw_in;
    end
endmodule

// File: rtl/pc_sequencer.sv
`timescale 1ns/1ps
module pc_sequencer
    import seq_pkg::*;
#(
    parameter int            AW        = 32,
    parameter int            CW        = 16,
    parameter int            PKT_BYTES = 8,
    parameter logic [AW-1:0] DBG_VEC   = 'hFFFF_F128,
    parameter logic [AW-1:0] IRQ_VEC   = 'hFFFF_F138
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              br_valid,
    input  logic [AW-1:0]     br_target,
    input  logic [AW-1:0]     loop_start,
    input  logic [AW-1:0]     loop_end,
    input  logic              cnt_we,
    input  logic [CW-1:0]     cnt_wdata,
    input  logic              psw_we,
    input  logic [PSW_W-1:0]  psw_wdata,
    input  logic [AW-1:0]     bkpt_addr,
    input  logic              irq,
    output logic [AW-1:0]     pc,
    output logic [CW-1:0]     loop_count,
    output logic [PSW_W-1:0]  psw,
    output logic [AW-1:0]     dbg_pc,
    output logic [PSW_W-1:0]  dbg_psw,
    output logic [AW-1:0]     bak_pc,
    output logic [PSW_W-1:0]  bak_psw,
    output logic              stk_bank,
    output logic              irq_pending
);
    logic [AW-1:0] pc_q, dpc_q, bpc_q;
    logic [CW-1:0] cnt_q;
    psw_t          psw_q, dpsw_q, bpsw_q;
    logic          bank_q, pend_q;

    psw_t          psw_exec, psw_loop, psw_trap, trap_saved, psw_s, psw_irq;
    logic [CW-1:0] cnt_loop, cnt_s;
    logic [AW-1:0] npc_loop, pc_trap, pc_s, pc_irq;
    logic          loop_back, trap_hit, dbg_take, irq_take, pend_nxt;

    assign psw_exec = (step && psw_we) ? psw_t'(psw_wdata) : psw_q;

    loop_ctrl #(.AW(AW), .CW(CW), .PKT_BYTES(PKT_BYTES)) u_loop (
        .pc(pc_q), .cnt(cnt_q), .rp_pre(psw_q.rp), .psw_exec(psw_exec),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .br_valid(br_valid), .br_target(br_target),
        .loop_start(loop_start), .loop_end(loop_end),
        .cnt_after(cnt_loop), .psw_after(psw_loop),
        .npc(npc_loop), .loop_back(loop_back)
    );

    trap_ctrl #(.AW(AW), .DBG_VEC(DBG_VEC)) u_trap (
        .cia(pc_q), .bkpt_addr(bkpt_addr), .psw_in(psw_loop), .npc(npc_loop),
        .take(trap_hit), .pc_out(pc_trap), .psw_out(psw_trap),
        .saved_psw(trap_saved)
    );

    always_comb begin
        dbg_take = step && trap_hit;
        pc_s     = step ? pc_trap  : pc_q;
        psw_s    = step ? psw_trap : psw_q;
        cnt_s    = step ? cnt_loop : cnt_q;
    end

    irq_ctrl #(.AW(AW), .IRQ_VEC(IRQ_VEC)) u_irq (
        .irq(irq), .pend(pend_q), .psw_in(psw_s), .pc_in(pc_s),
        .take(irq_take), .pend_next(pend_nxt), .pc_out(pc_irq), .psw_out(psw_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            cnt_q  <= '0;
            psw_q  <= '0;
            dpc_q  <= '0;
            dpsw_q <= '0;
            bpc_q  <= '0;
            bpsw_q <= '0;
            bank_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            pc_q   <= pc_irq;
            cnt_q  <= cnt_s;
            psw_q  <= psw_irq;
            pend_q <= pend_nxt;
            if (dbg_take) begin
                dpc_q  <= npc_loop;
                dpsw_q <= trap_saved;
            end
            if (irq_take) begin
                bpc_q  <= pc_s;
                bpsw_q <= psw_s;
            end
            if (irq_take || (step && psw_we))
                bank_q <= psw_irq.sm;
        end
    end

    assign pc          = pc_q;
    assign loop_count  = cnt_q;
    assign psw         = psw_q;
    assign dbg_pc      = dpc_q;
    assign dbg_psw     = dpsw_q;
    assign bak_pc      = bpc_q;
    assign bak_psw     = bpsw_q;
    assign stk_bank    = bank_q;
    assign irq_pending = pend_q;

    // R9: interrupt entry lands on the vector with a cleared status and bank 0
    p_irq_entry_r9: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> (pc == IRQ_VEC) && (psw == '0) && !stk_bank);

    // R7: debug trap lands on its vector with only DS and SM possibly set
    p_dbg_entry_r7: assert property (@(posedge clk) disable iff (rst)
        (dbg_take && !irq_take) |=> (pc == DBG_VEC) && psw[2] && (psw[4:3] == 2'b00) && (psw[1:0] == 2'b00));

    // R5: an unbranched loop-back goes to the loop start
    p_loop_back_r5: assert property (@(posedge clk) disable iff (rst)
        (step && loop_back && !br_valid && !dbg_take && !irq_take) |=> (pc == $past(loop_start)));

    // R12: idle cycles hold the sequencing state
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!step && !irq_take) |=> $stable(pc) && $stable(loop_count) && $stable(psw));

    // R10: a held request stays pending until it is delivered
    p_pend_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !irq_take) |=> irq_pending);

    // R3: a taken branch wins unless a trap follows
    p_branch_r3: assert property (@(posedge clk) disable iff (rst)
        (step && br_valid && !dbg_take && !irq_take) |=> (pc == $past(br_target)));
endmodule

// File: tb/pc_sequencer_bench.sv
`timescale 1ns/1ps
module pc_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0, br_valid = 1'b0, cnt_we = 1'b0, psw_we = 1'b0, irq = 1'b0;
    logic [31:0] br_target = '0, loop_start = 32'h100, loop_end = 32'h110, bkpt_addr = 32'hDEAD_0000;
    logic [15:0] cnt_wdata = '0;
    logic [5:0]  psw_wdata = '0;
    wire  [31:0] pc, dbg_pc, bak_pc;
    wire  [15:0] loop_count;
    wire  [5:0]  psw, dbg_psw, bak_psw;
    wire         stk_bank, irq_pending;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    // behavioural reference state
    logic [31:0] m_pc, m_dpc, m_bpc;
    logic [15:0] m_cnt;
    logic [5:0]  m_psw, m_dpsw, m_bpsw;
    logic        m_bank, m_pend;

    pc_sequencer u_pc_sequencer (
        .clk(clk), .rst(rst), .step(step), .br_valid(br_valid), .br_target(br_target),
        .loop_start(loop_start), .loop_end(loop_end), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .psw_we(psw_we), .psw_wdata(psw_wdata), .bkpt_addr(bkpt_addr), .irq(irq),
        .pc(pc), .loop_count(loop_count), .psw(psw), .dbg_pc(dbg_pc), .dbg_psw(dbg_psw),
        .bak_pc(bak_pc), .bak_psw(bak_psw), .stk_bank(stk_bank), .irq_pending(irq_pending)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_update();
        logic [31:0] p, np;
        logic [15:0] c;
        logic [5:0]  s;
        logic        before_nz, rp_now;
        if (rst) begin
            m_pc = 0; m_cnt = 0; m_psw = 0; m_dpc = 0; m_dpsw = 0;
            m_bpc = 0; m_bpsw = 0; m_bank = 0; m_pend = 0;
            return;
        end
        p = m_pc; c = m_cnt; s = m_psw;
        if (step) begin
            before_nz = (c != 0);
            if (p == loop_end && (before_nz || s[0])) c = c - 16'd1;
            if (cnt_we) c = cnt_wdata;
            if (psw_we) s = psw_wdata;
            rp_now = s[0];
            if (rp_now && p == loop_end && c == 0) s[0] = 1'b0;
            if (br_valid) np = br_target;
            else if (rp_now && before_nz && p == loop_end) np = loop_start;
            else np = p + 32'd8;
            if (p == bkpt_addr && s[3]) begin
                m_dpc  = np;
                s[4]   = 1'b1;
                m_dpsw = s;
                s      = (s & 6'b100000) | 6'b000100;
                np     = 32'hFFFF_F128;
            end
            if (psw_we) m_bank = s[5];
            p = np;
        end
        if (irq || m_pend) begin
            if (s[1]) begin
                m_bpsw = s; m_bpc = p; s = 0; p = 32'hFFFF_F138; m_bank = 0; m_pend = 0;
            end else begin
                m_pend = 1;
            end
        end
        m_pc = p; m_cnt = c; m_psw = s;
    endtask

    task automatic run1(input string tag);
        model_update();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        chk(tag, "pc", pc, m_pc);
        chk(tag, "loop_count", 32'(loop_count), 32'(m_cnt));
        chk(tag, "psw", 32'(psw), 32'(m_psw));
        chk(tag, "dbg_pc", dbg_pc, m_dpc);
        chk(tag, "dbg_psw", 32'(dbg_psw), 32'(m_dpsw));
        chk(tag, "bak_pc", bak_pc, m_bpc);
        chk(tag, "bak_psw", 32'(bak_psw), 32'(m_bpsw));
        chk(tag, "stk_bank", 32'(stk_bank), 32'(m_bank));
        chk(tag, "irq_pending", 32'(irq_pending), 32'(m_pend));
    endtask

    task automatic clear_in();
        step = 0; br_valid = 0; cnt_we = 0; psw_we = 0; irq = 0;
    endtask

    task automatic pkt(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            step = 1;
            run1(tag);
            clear_in();
        end
    endtask

    initial begin
        // R1: reset state
        rst = 1;
        run1("R1");
        run1("R1");
        rst = 0;
        // R2: straight-line packets
        pkt("R2", 3);
        // R12: idle cycle ignores all packet-side inputs
        br_valid = 1; br_target = 32'h4444; cnt_we = 1; cnt_wdata = 16'h7; psw_we = 1; psw_wdata = 6'b101011;
        run1("R12");
        run1("R12");
        clear_in();
        // R11: status write and stack bank
        psw_we = 1; psw_wdata = 6'b100000; pkt("R11", 1);
        psw_we = 1; psw_wdata = 6'b000000; pkt("R11", 1);
        // R3: branch into the loop body
        br_valid = 1; br_target = 32'h100; pkt("R3", 1);
        // R5 / R6: two-pass loop that exits by itself
        cnt_we = 1; cnt_wdata = 16'd2; psw_we = 1; psw_wdata = 6'b000001; pkt("R5", 1);
        pkt("R5", 4);
        pkt("R6", 4);
        // R4: count rewrite at the end address, then zero count with RP set
        br_valid = 1; br_target = 32'h110; cnt_we = 1; cnt_wdata = 16'd1; psw_we = 1; psw_wdata = 6'b000001;
        pkt("R4", 1);
        cnt_we = 1; cnt_wdata = 16'd5; pkt("R4", 1);
        cnt_we = 1; cnt_wdata = 16'd0; pkt("R4", 1);
        pkt("R4", 3);
        psw_we = 1; psw_wdata = 0; cnt_we = 1; cnt_wdata = 0; pkt("R4", 1);
        // R3: branch at the loop end beats the loop-back
        br_valid = 1; br_target = 32'h110; cnt_we = 1; cnt_wdata = 16'd3; psw_we = 1; psw_wdata = 6'b000001;
        pkt("R3", 1);
        br_valid = 1; br_target = 32'h2000; pkt("R3", 1);
        // R7: breakpoint two packets ahead
        psw_we = 1; psw_wdata = 6'b101000; pkt("R7", 1);
        bkpt_addr = m_pc + 32'd8;
        pkt("R7", 3);
        // R8: breakpoint on the loop end
        br_valid = 1; br_target = 32'h100; cnt_we = 1; cnt_wdata = 16'd1; psw_we = 1; psw_wdata = 6'b001001;
        bkpt_addr = 32'h110;
        pkt("R8", 1);
        pkt("R8", 3);
        bkpt_addr = 32'hDEAD_0000;
        // R9: unmasked interrupt together with a packet
        psw_we = 1; psw_wdata = 6'b100010; pkt("R9", 1);
        irq = 1; step = 1; run1("R9"); clear_in();
        pkt("R9", 2);
        // R10: masked bursts, then unmask
        irq = 1; run1("R10"); clear_in();
        pkt("R10", 2);
        irq = 1; step = 1; run1("R10"); clear_in();
        irq = 1; run1("R10"); clear_in();
        psw_we = 1; psw_wdata = 6'b000010; pkt("R10", 1);
        pkt("R10", 3);
        // mixed traffic across all rules
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 99);
            step     = (r < 80);
            br_valid = ($urandom_range(0, 9) == 0);
            case ($urandom_range(0, 3))
                0: br_target = 32'h100;
                1: br_target = 32'h108;
                2: br_target = 32'h110;
                default: br_target = 32'h0F8;
            endcase
            cnt_we    = ($urandom_range(0, 9) == 0);
            cnt_wdata = 16'($urandom_range(0, 3));
            psw_we    = ($urandom_range(0, 9) == 0);
            psw_wdata = 6'($urandom_range(0, 63));
            irq       = ($urandom_range(0, 19) == 0);
            bkpt_addr = ($urandom_range(0, 3) == 0) ? 32'h108 : 32'hDEAD_0000;
            run1("R2");
            clear_in();
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule